// File: doc/BRIEF.md
# Serial Programming Mode Entry Detector

This block decides when a device may switch from normal operation into its serial program/verify mode. It watches three asynchronous pad inputs: a reset/enable line and a two-wire serial port made of a serial clock and a serial data line. Entry takes a fixed sequence on these lines. First the enable line gives a short high pulse and falls. After a settling interval, a 32-bit entry key is clocked in on the data line. The enable line is then raised again and held. Only when the key matches exactly does the block raise its mode flag. While the flag is up, it also asks for the unused I/O to go high-impedance.

After the mode flag rises, a second guard interval runs before the data-accept gate opens. Downstream command logic must ignore serial traffic while the gate is closed. If the enable line drops at any point, the mode ends at once. A bad key also ends the attempt. The two guard intervals are counted in system clock cycles and set by parameters. All three pad inputs pass through a two-flop synchroniser.

The state machine has seven states. IDLE waits for the enable line to go high. PULSE waits for it to fall. LOW_WAIT counts the pre-key guard; serial clock edges in this state are not shifted. SHIFT collects the key bits. ARM means a matching key is held and the block waits for the enable line to rise. GUARD means the mode is active and the post-entry guard is counting. ACTIVE means the mode is active and the data gate is open.

The transitions are these:
- IDLE→PULSE when enable is high.
- PULSE→LOW_WAIT when enable falls.
- LOW_WAIT→PULSE when enable rises again.
- LOW_WAIT→SHIFT when the pre-key guard has expired.
- SHIFT→IDLE when enable rises.
- SHIFT→ARM when 32 bits have arrived and they match.
- SHIFT→IDLE when 32 bits have arrived and they do not match.
- ARM→GUARD when enable rises.
- GUARD→IDLE when enable falls.
- GUARD→ACTIVE when the post guard has expired.
- ACTIVE→IDLE when enable falls.

Top module: `prog_entry_detect`

## Requirements
- R1: After reset, `pv_mode`, `data_accept` and `io_hiz_req` are all 0.
- R2: The entry key is the 32-bit value 0x4D434850. After a pulse and a matching key, a rise of `en_pin` raises `pv_mode` exactly 3 clock cycles later: 2 synchroniser flops plus 1 state update.
- R3: Key bits are taken most significant bit first, one bit per rising edge of the synchronised `ser_clk`. A bit-reversed key does not give entry.
- R4: A key that differs in any bit returns the FSM to IDLE, and a later rise of `en_pin` does not raise `pv_mode`.
- R5: Rising `ser_clk` edges seen within PRE_GUARD cycles after the fall of `en_pin` are not shifted in.
- R6: `io_hiz_req` equals `pv_mode` on every cycle.
- R7: `data_accept` stays 0 for the first POST_GUARD cycles of `pv_mode` and rises exactly POST_GUARD cycles after `pv_mode` rises. It is never 1 without `pv_mode`.
- R8: When `en_pin` falls while the mode is active, all three outputs return to 0 exactly 3 cycles later.
- R9: A rise of `en_pin` while the key is being shifted aborts the attempt, and no mode is entered.
- R10: After a failed attempt, a fresh full sequence with the correct key enters the mode, because the shift register restarts empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_pin | input | 1 | Reset/enable pad, asynchronous |
| ser_clk | input | 1 | Serial clock pad, asynchronous |
| ser_dat | input | 1 | Serial data pad, asynchronous |
| pv_mode | output | 1 | Program/verify mode active |
| data_accept | output | 1 | Serial data may be interpreted |
| io_hiz_req | output | 1 | Request that unused I/O go high-impedance |

## Verification
Some properties are checked on every cycle:
- `io_hiz_req` always tracks `pv_mode`.
- `data_accept` never appears without `pv_mode` and never rises in the same cycle as it.
- The mode falls one cycle after the synchronised enable is seen low.
- The mode can only start from the armed state.
- The bit counter never passes 32.

Other behaviours can only be shown by the bench's scenarios:
- The exact entry latencies.
- The bit order of the key.
- Rejection of near-miss keys.
- Early clock edges being ignored during the pre-key guard.
- Recovery after an aborted or failed attempt.

// File: rtl/pe_pkg.sv
package pe_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULSE,
        ST_LOW_WAIT,
        ST_SHIFT,
        ST_ARM,
        ST_GUARD,
        ST_ACTIVE
    } pe_state_t;
endpackage

// File: rtl/pe_sync.sv
module pe_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= din;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/pe_shift.sv
module pe_shift #(
    parameter int KEY_W = 32,
    localparam int CNT_W = $clog2(KEY_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [KEY_W-1:0] word,
    output logic [CNT_W-1:0] bit_cnt,
    output logic             full
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(KEY_W);

    assign full = (bit_cnt == FULL_CNT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word    <= '0;
            bit_cnt <= '0;
        end else if (clr) begin
            word    <= '0;
            bit_cnt <= '0;
        end else if (shift_en && !full) begin
            word    <= {word[KEY_W-2:0], bit_in};
            bit_cnt <= bit_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pe_timer.sv
module pe_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          count <= '0;
        else if (clr)        count <= '0;
        else if (~&count)    count <= count + 1'b1;
    end
endmodule

// File: rtl/prog_entry_detect.sv
module prog_entry_detect #(
    parameter int          KEY_W      = 32,
    parameter logic [31:0] KEY_VAL    = 32'h4D434850,
    parameter int          PRE_GUARD  = 64,
    parameter int          POST_GUARD = 32,
    parameter int          SYNC_STG   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_pin,
    input  logic ser_clk,
    input  logic ser_dat,
    output logic pv_mode,
    output logic data_accept,
    output logic io_hiz_req
);
    import pe_pkg::*;

    localparam int MAX_GUARD = (PRE_GUARD > POST_GUARD) ? PRE_GUARD : POST_GUARD;
    localparam int TMR_W     = $clog2(MAX_GUARD + 1);
    localparam int CNT_W     = $clog2(KEY_W + 1);
    localparam logic [TMR_W-1:0] PRE_LAST  = TMR_W'(PRE_GUARD - 1);
    localparam logic [TMR_W-1:0] POST_LAST = TMR_W'(POST_GUARD - 1);
    localparam logic [KEY_W-1:0] KEY_REF   = KEY_W'(KEY_VAL);

    logic             en_s, sclk_s, sdat_s, sclk_d, sclk_rise;
    logic [KEY_W-1:0] key_word;
    logic [CNT_W-1:0] bit_cnt;
    logic             key_full;
    logic [TMR_W-1:0] tmr;
    pe_state_t        state_q, state_d;

    pe_sync #(.WIDTH(3), .STAGES(SYNC_STG)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({en_pin, ser_clk, ser_dat}),
        .dout ({en_s, sclk_s, sdat_s})
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end
    assign sclk_rise = sclk_s & ~sclk_d;

    pe_shift #(.KEY_W(KEY_W)) shift_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state_q != ST_SHIFT),
        .shift_en(state_q == ST_SHIFT && sclk_rise),
        .bit_in  (sdat_s),
        .word    (key_word),
        .bit_cnt (bit_cnt),
        .full    (key_full)
    );

    pe_timer #(.W(TMR_W)) timer_i (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (state_d != state_q),
        .count(tmr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (en_s) state_d = ST_PULSE;
            ST_PULSE:    if (!en_s) state_d = ST_LOW_WAIT;
            ST_LOW_WAIT: begin
                if (en_s)                 state_d = ST_PULSE;
                else if (tmr >= PRE_LAST) state_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (en_s)          state_d = ST_IDLE;
                else if (key_full) state_d = (key_word == KEY_REF) ? ST_ARM : ST_IDLE;
            end
            ST_ARM:      if (en_s) state_d = ST_GUARD;
            ST_GUARD: begin
                if (!en_s)                 state_d = ST_IDLE;
                else if (tmr >= POST_LAST) state_d = ST_ACTIVE;
            end
            ST_ACTIVE:   if (!en_s) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        pv_mode     = 1'b0;
        data_accept = 1'b0;
        unique case (state_q)
            ST_GUARD:  pv_mode = 1'b1;
            ST_ACTIVE: begin
                pv_mode     = 1'b1;
                data_accept = 1'b1;
            end
            default: ;
        endcase
        io_hiz_req = pv_mode;
    end
endmodule

// File: rtl/pe_checker.sv
module pe_checker #(
    parameter int KEY_W = 32,
    localparam int CNT_W = $clog2(KEY_W + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                en_s,
    input pe_pkg::pe_state_t   state_q,
    input logic [CNT_W-1:0]    bit_cnt,
    input logic                pv_mode,
    input logic                data_accept,
    input logic                io_hiz_req
);
    // R6
    hiz_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_hiz_req == pv_mode);

    // R7
    accept_needs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_accept |-> pv_mode);

    // R7
    accept_after_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_accept) |-> $past(pv_mode));

    // R8
    drop_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pv_mode && !en_s) |=> !pv_mode);

    // R4
    entry_from_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pv_mode) |-> $past(state_q == pe_pkg::ST_ARM));

    // R2
    bit_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(KEY_W));
endmodule

bind prog_entry_detect pe_checker #(.KEY_W(KEY_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_s       (en_s),
    .state_q    (state_q),
    .bit_cnt    (bit_cnt),
    .pv_mode    (pv_mode),
    .data_accept(data_accept),
    .io_hiz_req (io_hiz_req)
);

// File: tb/prog_entry_detect_tb.sv
module prog_entry_detect_tb_top;
    localparam int          PRE  = 64;
    localparam int          POST = 32;
    localparam logic [31:0] KEY  = 32'h4D434850;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_pin = 1'b0, ser_clk = 1'b0, ser_dat = 1'b0;
    logic pv_mode, data_accept, io_hiz_req;
    int   n_chk = 0, n_bad = 0;
    bit   done = 0;

    always #5 clk = ~clk;

    prog_entry_detect #(.PRE_GUARD(PRE), .POST_GUARD(POST)) dut_i (
        .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .ser_clk(ser_clk),
        .ser_dat(ser_dat), .pv_mode(pv_mode), .data_accept(data_accept),
        .io_hiz_req(io_hiz_req)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic outs(string req, logic pv, logic acc);
        chk(req, {29'd0, pv_mode, data_accept, io_hiz_req}, {29'd0, pv, acc, pv});
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_pulse();
        @(negedge clk) en_pin = 1'b1;
        wait_n(4);
        en_pin = 1'b0;
    endtask

    task automatic send_bit(logic b);
        ser_dat = b;
        wait_n(3);
        ser_clk = 1'b1;
        wait_n(4);
        ser_clk = 1'b0;
        wait_n(3);
    endtask

    task automatic send_bits(logic [31:0] w, int first, int last);
        for (int i = first; i >= last; i--) send_bit(w[i]);
    endtask

    // Raise enable and check the entry timing (R2, R6, R7), or absence of entry.
    task automatic raise_en(bit expect_entry, string req);
        @(negedge clk) en_pin = 1'b1;
        wait_n(2);
        outs(req, 1'b0, 1'b0);
        wait_n(1);
        outs(req, expect_entry, 1'b0);
        wait_n(POST - 1);
        outs(req, expect_entry, 1'b0);
        wait_n(1);
        outs(req, expect_entry, expect_entry);
        wait_n(10);
        outs(req, expect_entry, expect_entry);
    endtask

    // Drop enable; outputs must clear after 3 cycles (R8).
    task automatic drop_en(bit was_on);
        @(negedge clk) en_pin = 1'b0;
        wait_n(2);
        outs("R8", was_on, was_on);
        wait_n(1);
        outs("R8", 1'b0, 1'b0);
        wait_n(5);
    endtask

    task automatic full_attempt(logic [31:0] w, bit expect_entry, string req);
        do_pulse();
        wait_n(PRE + 10);
        send_bits(w, 31, 0);
        raise_en(expect_entry, req);
        drop_en(expect_entry);
    endtask

    task automatic t_reset();
        outs("R1", 1'b0, 1'b0);
    endtask

    task automatic t_good();
        full_attempt(KEY, 1'b1, "R2");
    endtask

    task automatic t_bad_key();
        full_attempt(KEY ^ 32'h1, 1'b0, "R4");
        full_attempt(KEY ^ 32'h8000_0000, 1'b0, "R4");
    endtask

    task automatic t_lsb_first();
        logic [31:0] rev;
        for (int i = 0; i < 32; i++) rev[i] = KEY[31-i];
        full_attempt(rev, 1'b0, "R3");
    endtask

    task automatic t_early_bits();
        do_pulse();
        wait_n(2);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        wait_n(PRE);
        send_bits(KEY, 31, 0);
        raise_en(1'b1, "R5");
        drop_en(1'b1);
    endtask

    task automatic t_abort();
        do_pulse();
        wait_n(PRE + 10);
        send_bits(KEY, 31, 16);
        @(negedge clk) en_pin = 1'b1;
        wait_n(3 + POST + 5);
        outs("R9", 1'b0, 1'b0);
        send_bits(KEY, 15, 0);
        outs("R9", 1'b0, 1'b0);
        @(negedge clk) en_pin = 1'b0;
        wait_n(10);
        outs("R9", 1'b0, 1'b0);
    endtask

    task automatic t_retry();
        full_attempt(32'h0, 1'b0, "R10");
        full_attempt(KEY, 1'b1, "R10");
    endtask

    initial begin
        wait_n(2);
        t_reset();
        rst_n = 1'b1;
        wait_n(3);
        t_reset();
        t_good();
        t_bad_key();
        t_lsb_first();
        t_early_bits();
        t_abort();
        t_retry();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule